// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Datapath

This block is a small 32-bit processor that finishes every instruction in one clock cycle. It fetches a word from an internal instruction array, decodes it, reads up to two operands from a 32-entry register file, runs them through an ALU, optionally touches an internal data array, and writes a result back. Instruction and data storage are separate arrays, so a fetch and a data access can happen in the same cycle. Every state element updates on the rising clock edge.

The supported instructions are the register-register operations add, sub, and, or, nor and set-less-than, plus word load, word store and branch-if-equal. While reset is held, a load port fills either array. A pair of observation ports then lets the environment read any register and any data word, so that the outcome of a program can be inspected after it has run.

Top module: `sc_core`

## Requirements
- R1: When no branch is taken, the PC advances by 4 on each clock edge; the instruction word is read from word index PC[IW+1:2] of the instruction array.
- R2: Instruction fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0]. Opcode 0x00 is register-register. funct 0x20 writes rs+rt to rd, and funct 0x22 writes rs-rt to rd, both modulo 2^32.
- R3: funct 0x24, 0x25 and 0x27 write the bitwise AND, OR and NOR of rs and rt to rd.
- R4: funct 0x2A writes 1 to rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R5: Opcode 0x23 (load) writes the data word at rs plus the sign-extended immediate into rt. Opcode 0x2B (store) writes rt to that address. The data word index is address bits [DW+1:2].
- R6: Stores and branches write no register.
- R7: Opcode 0x04 (branch-if-equal), with rs equal to rt, sets the next PC to PC+4 plus the sign-extended immediate shifted left by 2. This covers negative offsets.
- R8: A branch-if-equal whose operands differ falls through to PC+4.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: A synchronous active-high reset sets the PC to 0 and blocks register and data writes from the core. While the load port is enabled, it writes ld_data to the instruction array (ld_dmem=0) or to the data array (ld_dmem=1) at word ld_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load-port write enable |
| ld_dmem | input | 1 | Load target: 0 instruction array, 1 data array |
| ld_idx | input | LAW | Word index for the load port |
| ld_data | input | 32 | Word written by the load port |
| dbg_reg_sel | input | 5 | Register chosen for observation |
| dbg_reg_data | output | 32 | Value of the chosen register (register 0 reads zero) |
| dbg_mem_idx | input | DAW | Data word chosen for observation |
| dbg_mem_data | output | 32 | Value of the chosen data word |
| pc_o | output | 32 | Current program counter |

## Verification
The case that is hardest to reach from the ports is one where the register state depends on whether a branch went one way or the other. Without any immediate-arithmetic instruction, a register cannot be given a known value by an instruction alone. The bench therefore preloads the data array with the operand pair, a sentinel and a base address. A fixed program then loads them, applies every ALU operation, stores through a negative offset, and branches on equality over an instruction that overwrites the sentinel. It ends on a backward self-branch. Sweeping all ordered pairs from a set of corner values (zero, one, both signed extremes, all ones, an arbitrary pattern) covers overflow, signed comparison, and both the taken and the not-taken branch.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_en,
  input  logic           ld_dmem,
  input  logic [LAW-1:0] ld_idx,
  input  logic [31:0]    ld_data,
  input  logic [4:0]     dbg_reg_sel,
  output logic [31:0]    dbg_reg_data,
  input  logic [DAW-1:0] dbg_mem_idx,
  output logic [31:0]    dbg_mem_data,
  output logic [31:0]    pc_o
);
  localparam logic [5:0] OP_R = 6'h00, OP_LW = 6'h23, OP_SW = 6'h2B, OP_BEQ = 6'h04;

  logic [31:0] pc;
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf   [32];

  wire [31:0] instr = imem[pc[IAW+1:2]];
  wire [5:0]  op    = instr[31:26];
  wire [4:0]  rs    = instr[25:21];
  wire [4:0]  rt    = instr[20:16];
  wire [4:0]  rd    = instr[15:11];
  wire [5:0]  funct = instr[5:0];
  wire [31:0] simm  = {{16{instr[15]}}, instr[15:0]};

  wire is_r   = (op == OP_R);
  wire is_lw  = (op == OP_LW);
  wire is_sw  = (op == OP_SW);
  wire is_beq = (op == OP_BEQ);

  wire [31:0] rd1 = (rs == 5'd0) ? 32'd0 : rf[rs];
  wire [31:0] rd2 = (rt == 5'd0) ? 32'd0 : rf[rt];

  logic [3:0] alu_f;
  logic       r_ok;
  always_comb begin
    r_ok  = 1'b1;
    alu_f = 4'b0010;
    if (is_beq) alu_f = 4'b0110;
    else if (is_r) begin
      case (funct)
        6'h20:   alu_f = 4'b0010;
        6'h22:   alu_f = 4'b0110;
        6'h24:   alu_f = 4'b0000;
        6'h25:   alu_f = 4'b0001;
        6'h27:   alu_f = 4'b1100;
        6'h2A:   alu_f = 4'b0111;
        default: r_ok  = 1'b0;
      endcase
    end
  end

  wire [31:0] alu_b = (is_r || is_beq) ? rd2 : simm;
  logic [31:0] alu_y;
  always_comb begin
    case (alu_f)
      4'b0000: alu_y = rd1 & alu_b;
      4'b0001: alu_y = rd1 | alu_b;
      4'b0110: alu_y = rd1 - alu_b;
      4'b0111: alu_y = {31'd0, $signed(rd1) < $signed(alu_b)};
      4'b1100: alu_y = ~(rd1 | alu_b);
      default: alu_y = rd1 + alu_b;
    endcase
  end
  wire zero = (alu_y == 32'd0);

  wire [31:0] pc4    = pc + 32'd4;
  wire [31:0] br_tgt = pc4 + {simm[29:0], 2'b00};
  wire        take   = is_beq && zero;

  wire [DAW-1:0] dm_idx   = alu_y[DAW+1:2];
  wire [31:0]    dm_rdata = dmem[dm_idx];
  wire           dm_we    = !rst && is_sw;

  wire        rf_we = !rst && ((is_r && r_ok) || is_lw);
  wire [4:0]  wa    = is_r ? rd : rt;
  wire [31:0] wd    = is_lw ? dm_rdata : alu_y;

  always_ff @(posedge clk) begin
    if (rst)       pc <= 32'd0;
    else if (take) pc <= br_tgt;
    else           pc <= pc4;
  end

  always_ff @(posedge clk) begin
    if (rf_we && wa != 5'd0) rf[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (ld_en && !ld_dmem) imem[ld_idx[IAW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_en && ld_dmem) dmem[ld_idx[DAW-1:0]] <= ld_data;
    else if (dm_we)       dmem[dm_idx] <= rd2;
  end

  assign dbg_reg_data = (dbg_reg_sel == 5'd0) ? 32'd0 : rf[dbg_reg_sel];
  assign dbg_mem_data = dmem[dbg_mem_idx];
  assign pc_o         = pc;
endmodule

module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [5:0]  op,
  input logic [4:0]  rs,
  input logic [31:0] rd1,
  input logic [31:0] simm,
  input logic        take,
  input logic        rf_we,
  input logic        dm_we
);
  assert_pc_step_R1: assert property (@(posedge clk) disable iff (rst)
    !take |=> pc == $past(pc) + 32'd4);

  assert_branch_target_R7: assert property (@(posedge clk) disable iff (rst)
    take |=> pc == $past(pc) + 32'd4 + {$past(simm[29:0]), 2'b00});

  assert_no_reg_write_R6: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h2B || op == 6'h04) |-> !rf_we);

  assert_store_only_R5: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> op == 6'h2B);

  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (rst)
    rs == 5'd0 |-> rd1 == 32'd0);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc), .op(op), .rs(rs), .rd1(rd1),
  .simm(simm), .take(take), .rf_we(rf_we), .dm_we(dm_we)
);

// File: tb/sc_core_bench.sv
module sc_core_bench;
  localparam int LAW = 6, DAW = 6;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ld_en = 1'b0, ld_dmem = 1'b0;
  logic [LAW-1:0] ld_idx = '0;
  logic [31:0]    ld_data = '0;
  logic [4:0]     dbg_reg_sel = '0;
  logic [DAW-1:0] dbg_mem_idx = '0;
  logic [31:0]    dbg_reg_data, dbg_mem_data, pc_o;

  int checks = 0, fails = 0, cyc = 0;

  sc_core u_sc_core (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem), .ld_idx(ld_idx),
    .ld_data(ld_data), .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
    .dbg_mem_idx(dbg_mem_idx), .dbg_mem_data(dbg_mem_data), .pc_o(pc_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] rt_op(input logic [4:0] d, s, t, input logic [5:0] f);
    return {6'h00, s, t, d, 5'd0, f};
  endfunction
  function automatic logic [31:0] it_op(input logic [5:0] o, input logic [4:0] s, t, input logic [15:0] im);
    return {o, s, t, im};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic dm, input int idx, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_dmem = dm; ld_idx = idx[LAW-1:0]; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic reg_is(input string req, input int r, input logic [31:0] exp);
    dbg_reg_sel = r[4:0];
    #1 chk(req, dbg_reg_data, exp);
  endtask
  task automatic mem_is(input string req, input int i, input logic [31:0] exp);
    dbg_mem_idx = i[DAW-1:0];
    #1 chk(req, dbg_mem_data, exp);
  endtask

  logic [31:0] vals [6] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
  logic [31:0] prog [17];

  initial begin
    prog[0]  = it_op(6'h23, 0, 1, 16'd0);
    prog[1]  = it_op(6'h23, 0, 2, 16'd4);
    prog[2]  = it_op(6'h23, 0, 9, 16'd8);
    prog[3]  = it_op(6'h23, 0, 11, 16'd12);
    prog[4]  = rt_op(3, 1, 2, 6'h20);
    prog[5]  = rt_op(4, 1, 2, 6'h22);
    prog[6]  = rt_op(5, 1, 2, 6'h24);
    prog[7]  = rt_op(6, 1, 2, 6'h25);
    prog[8]  = rt_op(7, 1, 2, 6'h27);
    prog[9]  = rt_op(8, 1, 2, 6'h2A);
    prog[10] = rt_op(0, 1, 2, 6'h20);
    prog[11] = it_op(6'h2B, 0, 3, 16'd16);
    prog[12] = it_op(6'h2B, 11, 4, 16'hFFFC);
    prog[13] = it_op(6'h04, 1, 2, 16'd1);
    prog[14] = rt_op(9, 1, 0, 6'h20);
    prog[15] = rt_op(10, 2, 0, 6'h20);
    prog[16] = it_op(6'h04, 0, 0, 16'hFFFF);

    rst = 1'b1;
    for (int i = 0; i < 17; i++) load(1'b0, i, prog[i]);
    @(negedge clk);
    chk("R10 reset pc", pc_o, 32'd0);

    for (int ia = 0; ia < 6; ia++) begin
      for (int ib = 0; ib < 6; ib++) begin
        logic [31:0] a, b;
        a = vals[ia]; b = vals[ib];
        rst = 1'b1;
        load(1'b1, 0, a);
        load(1'b1, 1, b);
        load(1'b1, 2, 32'hDEAD_BEEF);
        load(1'b1, 3, 32'd16);
        @(negedge clk);
        chk("R10 pc held in reset", pc_o, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pc after one step", pc_o, 32'd4);
        repeat (19) @(negedge clk);
        chk("R7 backward self-branch pc", pc_o, 32'd64);
        reg_is("R5 load rt", 1, a);
        reg_is("R2 add", 3, a + b);
        reg_is("R2 sub", 4, a - b);
        reg_is("R3 and", 5, a & b);
        reg_is("R3 or", 6, a | b);
        reg_is("R3 nor", 7, ~(a | b));
        reg_is("R4 slt", 8, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        reg_is("R9 r0 write ignored", 0, 32'd0);
        reg_is(a == b ? "R7 taken branch skips" : "R8 untaken falls through", 9,
               a == b ? 32'hDEAD_BEEF : a);
        reg_is("R1 sequential after branch", 10, b);
        reg_is("R6 store leaves base reg", 11, 32'd16);
        mem_is("R5 store positive offset", 4, a + b);
        mem_is("R5 store negative offset", 3, a - b);
        mem_is("R10 load port data kept", 0, a);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule